// File: doc/BRIEF.md
# Protection Unit Region Checker

This block decides, for every memory request, whether a 32-bit address may be read, written or executed. It holds a small set of programmable protection regions. Each region has a base address, a size/enable word and an access-control word, and software loads them through a one-word write port. A request is described by its address, its access kind, a privilege flag and three mode bits: unit enable, background-map enable and high vectors. Within the same cycle the block returns allow or deny, a fault status code and the permission set it resolved.

Regions are searched from the highest index down, so a higher-numbered region overrides the lower ones it overlaps. In regions of 256 bytes or more, each eighth of the region can be switched off. A request that lands in a switched-off eighth is passed on to the lower-numbered regions. When the unit is off, or when a privileged request with background enable set matches no region, a fixed default map supplies the permissions. The check is purely combinational from the stored region words and the request. A register write becomes visible to requests from the clock edge that stores it.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every region word is zero, so no region matches. With the unit on, a privileged request with background enable set gets the default map, and a user request gets a background fault.
- R2: A write with `cfgWe` high stores `cfgData` into region `cfgIdx` at the next rising clock edge. `cfgSel` chooses the word: 0 is the base, 1 is size/enable and 2 is access control. A `cfgSel` of 3, or an index at or above `NUM_REGIONS`, changes nothing.
- R3: In the size/enable word, bit 0 enables the region and bits 5:1 hold N. The region covers 2^(N+1) bytes from base to base plus size minus one inclusive. A region with N equal to 0 never matches.
- R4: A region whose base has any bit set below its size boundary never matches.
- R5: When several regions match, the one with the highest index decides the permissions.
- R6: A region of 256 bytes or more is split into 8 equal parts. The part index is (address − base) >> (N+1−3), and bits 15:8 of the size/enable word disable parts 0 to 7. If the hit part is disabled, that region is treated as a miss and the search continues downward.
- R7: In the access-control word, bits 10:8 hold the permission code AP and bit 12 is execute-never. A set execute-never bit removes execute permission whatever AP says.
- R8: For user requests, AP 3 grants read, write and execute, and AP 2 or 6 grants read and execute. AP 0, 1, 4, 5 and 7 grant nothing.
- R9: For privileged requests, AP 1, 2 or 3 grants read, write and execute, and AP 5 or 6 grants read and execute. AP 0, 4 and 7 grant nothing.
- R10: The default map grants read and write everywhere. It grants execute below 0x8000_0000, and at 0xF000_0000 and above only while `hiVec` is high. There is no execute between those two ranges.
- R11: With the unit on and no region matching, a user request, or a privileged request with `bgEn` low, is denied with status 0 and an empty permission set. Otherwise the default map applies.
- R12: `perm` bit 0 is read, bit 1 is write and bit 2 is execute. `reqType` 0, 1 and 2 ask for read, write and execute. If the asked bit is absent, or `reqType` is 3, the request is denied with status 0x0D unless R11 has already faulted it. An allowed request reports status 0.
- R13: While `unitEn` is low the default map applies, whatever the regions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the region storage |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Region word write strobe |
| cfgIdx | input | IDX_W | Region index for the write |
| cfgSel | input | 2 | Word select: 0 base, 1 size/enable, 2 access control, 3 none |
| cfgData | input | 32 | Write data |
| reqAddr | input | 32 | Request address |
| reqType | input | 2 | 0 read, 1 write, 2 execute, 3 invalid |
| reqPriv | input | 1 | High for a privileged request |
| unitEn | input | 1 | Protection unit enable |
| bgEn | input | 1 | Default map as background for privileged misses |
| hiVec | input | 1 | Allow execute in the top 256 MB of the default map |
| allow | output | 1 | Request permitted |
| faultStatus | output | 5 | 0x00 background fault or allowed, 0x0D permission fault |
| perm | output | 3 | Resolved permissions {execute, write, read} |

## Verification
The hardest case to reach from the ports is a chain of fall-throughs: a high region hit in a disabled part, a misaligned or zero-size region in between, and a lower region or the background rule deciding the result. Directed sequences build overlapping regions on the same base and then disable single parts. This moves one address between the overlapping owners. A random phase then places many aligned and misaligned regions inside a small window, with random part-disable masks, and aims most addresses at that window so that overlaps and fall-throughs happen often. An independent loop-based model predicts every result.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int MAX_IDX_W = 5;
  localparam logic [4:0] FAULT_NONE = 5'h00;
  localparam logic [4:0] FAULT_PERM = 5'h0D;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_ACC  = 2'd2,
    SEL_NONE = 2'd3
  } cfgSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 baseWe;
    logic                 sizeWe;
    logic                 accWe;
    logic [MAX_IDX_W-1:0] idx;
  } wrStrobe_t;

  // Search result from datapath to control
  typedef struct packed {
    logic       anyHit;
    logic [2:0] hitPerm;
    logic [2:0] defPerm;
  } dpStat_t;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match (
  input  logic [31:0] base,
  input  logic        en,
  input  logic [4:0]  sizeN,
  input  logic [7:0]  srDis,
  input  logic [31:0] addr,
  output logic        hit
);
  logic [5:0]  expo;
  logic [5:0]  subShift;
  logic [31:0] lowMask;
  logic [31:0] offs;
  logic [2:0]  subIdx;
  logic        aligned;
  logic        inRange;
  logic        subOff;

  always_comb begin
    expo     = {1'b0, sizeN} + 6'd1;
    lowMask  = ~(32'hFFFF_FFFF << expo);
    offs     = addr - base;
    subShift = expo - 6'd3;
    subIdx   = 3'(offs >> subShift);
    aligned  = (base & lowMask) == 32'd0;
    inRange  = (addr & ~lowMask) == base;
    subOff   = (expo >= 6'd8) && srDis[subIdx];
    hit      = en && (sizeN != 5'd0) && aligned && inRange && !subOff;
  end
endmodule

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W = 3
) (
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [1:0]       cfgSel,
  input  logic [1:0]       reqType,
  input  logic             reqPriv,
  input  logic             unitEn,
  input  logic             bgEn,
  input  dpStat_t          dpStat,
  output wrStrobe_t        wrStb,
  output logic             allow,
  output logic [4:0]       faultStatus,
  output logic [2:0]       perm
);
  logic       idxOk;
  logic       bgFault;
  logic [2:0] needBit;

  always_comb begin
    idxOk        = 32'(cfgIdx) < NUM_REGIONS;
    wrStb.idx    = MAX_IDX_W'(cfgIdx);
    wrStb.baseWe = cfgWe && idxOk && (cfgSel == SEL_BASE);
    wrStb.sizeWe = cfgWe && idxOk && (cfgSel == SEL_SIZE);
    wrStb.accWe  = cfgWe && idxOk && (cfgSel == SEL_ACC);
  end

  always_comb begin
    bgFault = 1'b0;
    if (!unitEn)             perm = dpStat.defPerm;
    else if (dpStat.anyHit)  perm = dpStat.hitPerm;
    else if (!reqPriv || !bgEn) begin
      bgFault = 1'b1;
      perm    = 3'b000;
    end
    else                     perm = dpStat.defPerm;

    case (reqType)
      2'd0:    needBit = 3'b001;
      2'd1:    needBit = 3'b010;
      2'd2:    needBit = 3'b100;
      default: needBit = 3'b000;
    endcase

    allow = !bgFault && ((perm & needBit) != 3'b000);
    if (allow || bgFault) faultStatus = FAULT_NONE;
    else                  faultStatus = FAULT_PERM;
  end
endmodule

// File: rtl/mpu_dp.sv
module mpu_dp
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  wrStrobe_t   wrStb,
  input  logic [31:0] cfgData,
  input  logic [31:0] reqAddr,
  input  logic        reqPriv,
  input  logic        hiVec,
  output dpStat_t     dpStat
);
  logic [NUM_REGIONS-1:0] hitVec;
  logic [3:0]             accVec [NUM_REGIONS];
  logic [3:0]             selAcc;
  logic                   anyHit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [31:0] baseQ;
    logic [13:0] sizeQ;   // {srDis[7:0], sizeN[4:0], en}
    logic [3:0]  accQ;    // {xn, ap[2:0]}
    logic        selMe;

    assign selMe = wrStb.idx == MAX_IDX_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        sizeQ <= '0;
        accQ  <= '0;
      end else if (selMe) begin
        if (wrStb.baseWe) baseQ <= cfgData;
        if (wrStb.sizeWe) sizeQ <= {cfgData[15:8], cfgData[5:0]};
        if (wrStb.accWe)  accQ  <= {cfgData[12], cfgData[10:8]};
      end
    end

    mpu_region_match u_match (
      .base  (baseQ),
      .en    (sizeQ[0]),
      .sizeN (sizeQ[5:1]),
      .srDis (sizeQ[13:6]),
      .addr  (reqAddr),
      .hit   (hitVec[g])
    );

    assign accVec[g] = accQ;
  end

  // Later (higher) index overrides earlier
  always_comb begin
    anyHit = 1'b0;
    selAcc = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        selAcc = accVec[i];
      end
    end
  end

  function automatic logic [2:0] decodeAp(input logic [2:0] ap, input logic priv);
    logic [2:0] p;
    if (priv) begin
      case (ap)
        3'd1, 3'd2, 3'd3: p = 3'b111;
        3'd5, 3'd6:       p = 3'b101;
        default:          p = 3'b000;
      endcase
    end else begin
      case (ap)
        3'd3:       p = 3'b111;
        3'd2, 3'd6: p = 3'b101;
        default:    p = 3'b000;
      endcase
    end
    return p;
  endfunction

  logic [2:0] apPerm;
  logic       defExec;

  always_comb begin
    apPerm         = decodeAp(selAcc[2:0], reqPriv);
    dpStat.anyHit  = anyHit;
    dpStat.hitPerm = {apPerm[2] & ~selAcc[3], apPerm[1:0]};
    defExec        = !reqAddr[31] || ((reqAddr[31:28] == 4'hF) && hiVec);
    dpStat.defPerm = {defExec, 2'b11};
  end
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [1:0]       cfgSel,
  input  logic [31:0]      cfgData,
  input  logic [31:0]      reqAddr,
  input  logic [1:0]       reqType,
  input  logic             reqPriv,
  input  logic             unitEn,
  input  logic             bgEn,
  input  logic             hiVec,
  output logic             allow,
  output logic [4:0]       faultStatus,
  output logic [2:0]       perm
);
  wrStrobe_t wrStb;
  dpStat_t   dpStat;

  mpu_ctrl #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_ctrl (
    .cfgWe       (cfgWe),
    .cfgIdx      (cfgIdx),
    .cfgSel      (cfgSel),
    .reqType     (reqType),
    .reqPriv     (reqPriv),
    .unitEn      (unitEn),
    .bgEn        (bgEn),
    .dpStat      (dpStat),
    .wrStb       (wrStb),
    .allow       (allow),
    .faultStatus (faultStatus),
    .perm        (perm)
  );

  mpu_dp #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .cfgData (cfgData),
    .reqAddr (reqAddr),
    .reqPriv (reqPriv),
    .hiVec   (hiVec),
    .dpStat  (dpStat)
  );
endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] reqAddr,
  input logic [1:0]  reqType,
  input logic        unitEn,
  input logic        hiVec,
  input logic        allow,
  input logic [4:0]  faultStatus,
  input logic [2:0]  perm
);
  // R12: only two fault codes exist
  p_status_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    !allow |-> (faultStatus == 5'h00 || faultStatus == 5'h0D));

  // R12: allowed requests report status 0
  p_allow_clean_r12: assert property (@(posedge clk) disable iff (!rstN)
    allow |-> faultStatus == 5'h00);

  // R12: a grant always carries the requested permission bit
  p_grant_has_bit_r12: assert property (@(posedge clk) disable iff (!rstN)
    allow |-> (reqType != 2'd3 && perm[reqType]));

  // R11: a background fault leaves an empty permission set
  p_bgfault_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!allow && faultStatus == 5'h00) |-> perm == 3'b000);

  // R13: unit off never background-faults and is always read/write
  p_unit_off_rw_r13: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |-> (perm[1:0] == 2'b11 && (allow || faultStatus == 5'h0D)));

  // R10: top region not executable in the default map without high vectors
  p_hivec_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!unitEn && !hiVec && reqAddr[31:28] == 4'hF) |-> !perm[2]);
endmodule

bind mpu_region_check mpu_region_check_sva u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .reqAddr     (reqAddr),
  .reqType     (reqType),
  .unitEn      (unitEn),
  .hiVec       (hiVec),
  .allow       (allow),
  .faultStatus (faultStatus),
  .perm        (perm)
);

// File: tb/tb_mpu_region_check.sv
module tb_mpu_region_check;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [1:0]    cfgSel = 2'd3;
  logic [31:0]   cfgData = '0;
  logic [31:0]   reqAddr = '0;
  logic [1:0]    reqType = '0;
  logic          reqPriv = 1'b0;
  logic          unitEn = 1'b0;
  logic          bgEn = 1'b0;
  logic          hiVec = 1'b0;
  logic          allow;
  logic [4:0]    faultStatus;
  logic [2:0]    perm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mBase [NR];
  logic [31:0] mSize [NR];
  logic [31:0] mAcc  [NR];

  mpu_region_check #(.NUM_REGIONS(NR)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgSel(cfgSel),
    .cfgData(cfgData), .reqAddr(reqAddr), .reqType(reqType), .reqPriv(reqPriv),
    .unitEn(unitEn), .bgEn(bgEn), .hiVec(hiVec), .allow(allow),
    .faultStatus(faultStatus), .perm(perm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: returns {allow, status[4:0], perm[2:0]}
  function automatic logic [8:0] refCheck(logic [31:0] a32, int typ, bit priv,
                                          bit ue, bit bg, bit hv);
    int win = -1;
    int p = 0;
    bit bgf = 0;
    bit ok;
    longint unsigned a = a32;
    int dflt = 3;
    if (a < 64'h8000_0000 || (a >= 64'hF000_0000 && hv)) dflt = 7;
    if (ue) begin
      for (int r = NR - 1; r >= 0; r--) begin
        int n = int'(mSize[r][5:1]);
        longint unsigned b = mBase[r];
        longint unsigned sz;
        if (!mSize[r][0] || n == 0) continue;
        sz = 64'd1 << (n + 1);
        if (b % sz != 0) continue;
        if (a < b || a >= b + sz) continue;
        if (n + 1 >= 8) begin
          int part = int'((a - b) / (sz / 8));
          if (mSize[r][8 + part]) continue;
        end
        win = r;
        break;
      end
    end
    if (!ue) p = dflt;
    else if (win >= 0) begin
      int ap = int'(mAcc[win][10:8]);
      if (priv) p = (ap >= 1 && ap <= 3) ? 7 : (ap == 5 || ap == 6) ? 5 : 0;
      else      p = (ap == 3) ? 7 : (ap == 2 || ap == 6) ? 5 : 0;
      if (mAcc[win][12]) p = p & 3;
    end
    else if (!priv || !bg) bgf = 1;
    else p = dflt;
    ok = !bgf && typ < 3 && ((p >> typ) & 1) == 1;
    return {ok, (ok || bgf) ? 5'h00 : 5'h0D, 3'(p)};
  endfunction

  task automatic cfgWrite(int idx, int sel, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = IW'(idx); cfgSel = 2'(sel); cfgData = d;
    @(posedge clk);
    #1;
    cfgWe = 1'b0;
    if (idx < NR) begin
      if (sel == 0) mBase[idx] = d;
      else if (sel == 1) mSize[idx] = d;
      else if (sel == 2) mAcc[idx] = d;
    end
  endtask

  task automatic chk(string tag, logic [31:0] a, int typ, bit priv, bit ue, bit bg, bit hv);
    logic [8:0] exp;
    reqAddr = a; reqType = 2'(typ); reqPriv = priv; unitEn = ue; bgEn = bg; hiVec = hv;
    @(negedge clk);
    exp = refCheck(a, typ, priv, ue, bg, hv);
    checks++;
    if ({allow, faultStatus, perm} !== exp) begin
      errors++;
      $display("FAIL %s addr=%h type=%0d priv=%0d: got allow=%0b st=%h perm=%b exp allow=%0b st=%h perm=%b",
               tag, a, typ, priv, allow, faultStatus, perm, exp[8], exp[7:3], exp[2:0]);
    end
  endtask

  function automatic logic [31:0] szWord(int n, logic [7:0] dis, bit en);
    return {16'd0, dis, 2'b00, 5'(n), en};
  endfunction

  function automatic logic [31:0] accWord(int ap, bit xn);
    return {19'd0, xn, 1'b0, 3'(ap), 8'd0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mBase[i] = 0; mSize[i] = 0; mAcc[i] = 0; end
    // R1: reset state, checked during and after reset
    chk("R1", 32'h0000_1000, 0, 0, 1, 1, 0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1", 32'h0000_1000, 2, 1, 1, 1, 0);
    chk("R1", 32'h0000_1000, 0, 0, 1, 1, 0);

    // R10 / R13: default map with unit off
    chk("R10", 32'hF000_0010, 2, 0, 0, 0, 0);
    chk("R10", 32'hF000_0010, 2, 0, 0, 0, 1);
    chk("R10", 32'h9000_0000, 2, 1, 0, 1, 1);
    chk("R10", 32'h7FFF_FFFC, 2, 0, 0, 0, 0);
    chk("R10", 32'h9000_0000, 1, 0, 0, 0, 0);

    // R2 / R3: region 0, 4 KB, AP 3
    cfgWrite(0, 0, 32'h2000_0000);
    cfgWrite(0, 2, accWord(3, 0));
    cfgWrite(0, 1, szWord(11, 8'h00, 1));
    chk("R2", 32'h2000_0100, 1, 0, 1, 0, 0);
    chk("R3", 32'h2000_0FFF, 0, 0, 1, 0, 0);
    chk("R3", 32'h2000_1000, 0, 0, 1, 0, 0);

    // R5: region 1 overlaps, 1 KB, AP 6
    cfgWrite(1, 0, 32'h2000_0000);
    cfgWrite(1, 2, accWord(6, 0));
    cfgWrite(1, 1, szWord(9, 8'h00, 1));
    chk("R5", 32'h2000_0010, 1, 0, 1, 0, 0);
    chk("R5", 32'h2000_0500, 1, 0, 1, 0, 0);

    // R6: disable part 2 of region 1 (128-byte parts)
    cfgWrite(1, 1, szWord(9, 8'h04, 1));
    chk("R6", 32'h2000_0100, 1, 0, 1, 0, 0);
    chk("R6", 32'h2000_0080, 1, 0, 1, 0, 0);
    chk("R6", 32'h2000_0180, 1, 0, 1, 0, 0);

    // R7: execute-never
    cfgWrite(1, 2, accWord(6, 1));
    chk("R7", 32'h2000_0080, 2, 0, 1, 0, 0);
    chk("R7", 32'h2000_0080, 0, 0, 1, 0, 0);

    // R3: size field 0 is skipped
    cfgWrite(2, 0, 32'h2000_0000);
    cfgWrite(2, 2, accWord(0, 0));
    cfgWrite(2, 1, szWord(0, 8'h00, 1));
    chk("R3", 32'h2000_0000, 0, 0, 1, 0, 0);

    // R4: misaligned base is skipped
    cfgWrite(3, 0, 32'h2000_0040);
    cfgWrite(3, 2, accWord(0, 0));
    cfgWrite(3, 1, szWord(9, 8'h00, 1));
    chk("R4", 32'h2000_0080, 0, 1, 1, 0, 0);

    // R2: select 3 writes nothing
    cfgWrite(1, 3, 32'h0000_0000);
    chk("R2", 32'h2000_0080, 0, 0, 1, 0, 0);

    // R8 / R9: AP sweep on region 4
    cfgWrite(4, 0, 32'h4000_0000);
    cfgWrite(4, 1, szWord(15, 8'h00, 1));
    for (int ap = 0; ap < 8; ap++) begin
      cfgWrite(4, 2, accWord(ap, 0));
      for (int t = 0; t < 3; t++) begin
        chk("R8", 32'h4000_0040, t, 0, 1, 1, 0);
        chk("R9", 32'h4000_0040, t, 1, 1, 1, 0);
      end
    end

    // R11: misses
    chk("R11", 32'h5000_0000, 0, 1, 1, 1, 0);
    chk("R11", 32'h5000_0000, 0, 1, 1, 0, 0);
    chk("R11", 32'h5000_0000, 0, 0, 1, 1, 0);

    // R12: type 3 is always refused
    chk("R12", 32'h2000_0500, 3, 0, 1, 0, 0);
    chk("R12", 32'h0000_0000, 3, 1, 0, 0, 0);

    // R13: regions ignored while the unit is off
    chk("R13", 32'h2000_0080, 1, 0, 0, 0, 0);

    // R6: full 4 GB region, top part disabled
    cfgWrite(7, 0, 32'h0000_0000);
    cfgWrite(7, 2, accWord(1, 0));
    cfgWrite(7, 1, szWord(31, 8'h80, 1));
    chk("R6", 32'h6000_0000, 0, 0, 1, 1, 0);
    chk("R6", 32'hF000_0000, 0, 1, 1, 1, 1);
    chk("R6", 32'hF000_0000, 2, 0, 1, 1, 1);

    // Random phase: crowded window
    for (int k = 0; k < 40; k++) begin
      int idx = int'($urandom_range(NR - 1, 0));
      int n = int'($urandom_range(20, 6));
      logic [31:0] b = 32'h1000_0000 + (32'($urandom_range(15, 0)) << (n + 1));
      if ($urandom_range(7, 0) == 0) b = b + 32'h40;
      cfgWrite(idx, 0, b);
      cfgWrite(idx, 2, accWord(int'($urandom_range(7, 0)), 1'($urandom_range(1, 0))));
      cfgWrite(idx, 1, szWord(n, 8'($urandom), $urandom_range(5, 0) != 0));
      for (int j = 0; j < 20; j++) begin
        logic [31:0] a = 32'h1000_0000 + ($urandom & 32'h003F_FFFF);
        if ($urandom_range(9, 0) == 0) a = $urandom;
        chk("R5", a, int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
            $urandom_range(7, 0) != 0, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule